// File: doc/BRIEF.md
# GPIO Port with Per-Line Interrupt Routing

This block is a memory-mapped general-purpose I/O port of up to 32 lines. Software sees a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. Each line has three things. The first is an output value, together with a direction bit that enables the pad driver. The second is a sampled input value that passes through a two-flop synchroniser. The third is an interrupt condition, which the line computes from its own polarity and edge-select bits.

The polarity and edge-select bits of a line, taken together, place it in one of four trigger kinds. TRIG_LVL_LOW (edge 0, polarity 0) is active while the line is low. TRIG_LVL_HIGH (edge 0, polarity 1) is active while it is high. TRIG_EDGE_FALL (edge 1, polarity 0) produces a one-cycle pulse on a high-to-low change of the synchronised sample. TRIG_EDGE_RISE (edge 1, polarity 1) produces a one-cycle pulse on a low-to-high change. A line moves between these kinds only through register writes; there is no other transition.

A masked-in condition is routed by the line's map register onto one of the shared interrupt outputs, or onto none. Every interrupt output is the OR of all lines routed to it.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output, direction, mask, polarity, edge and map registers all read 0, and pin_out, pin_oe and irq_out are all 0.
- R2: Register 0x04 holds the output value and register 0x08 holds the direction. Both read back what was written. pin_out follows register 0x04, and pin_oe follows register 0x08 (1 = drive), from the cycle after the write.
- R3: Register 0x00 returns the synchronised input. A change on pin_in is visible there two clock edges later. Writes to 0x00 change no register and no pin.
- R4: With mask=1, edge (0x14) = 0 and polarity (0x10) = 0, the line's interrupt is active while its synchronised input is low.
- R5: With mask=1, edge=0 and polarity=1, the line's interrupt is active while its synchronised input is high.
- R6: With mask=1, edge=1 and polarity=0, a falling input gives a one-cycle interrupt pulse two edges after the change. A steady input gives none.
- R7: With mask=1, edge=1 and polarity=1, a rising input gives a one-cycle interrupt pulse two edges after the change.
- R8: A line whose bit in the mask register (0x0C) is 0 never drives any interrupt output, whatever its input does.
- R9: The map register of line j sits at 0x20+4*j. Bit 8 enables routing and bits [IDXW-1:0] select the output index. With bit 8 clear the line routes nowhere. Other bits are not stored and read 0.
- R10: Several lines may share one output, and that output is the OR of their conditions. Lines routed to different outputs act independently.
- R11: Bits for lines at or above NLINES read 0 and ignore writes. So do map addresses of unimplemented lines, and unassigned offsets such as 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NLINES | Asynchronous line inputs |
| pin_out | output | NLINES | Output value per line |
| pin_oe | output | NLINES | Output enable per line |
| irq_out | output | NIRQ | Shared interrupt outputs |

## Verification
Some properties can be checked on every cycle, and the embedded assertions cover these:
- An edge-mode condition never lasts more than one cycle while the configuration stays the same.
- No output fires when every map is disabled or every mask is clear.
- pin_oe follows a direction write.
- A write to the input register disturbs no pin.
- The port is quiet as reset releases.

The bench scenarios cover what depends on the input history:
- the two-edge synchroniser latency;
- the level polarity of each trigger kind;
- the exact cycle of an edge pulse;
- which output index a line lands on;
- the OR-merge of shared lines;
- the handling of unimplemented bits and offsets.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int OFF_DATA  = 'h00;
    localparam int OFF_OUT   = 'h04;
    localparam int OFF_DIR   = 'h08;
    localparam int OFF_MASK  = 'h0C;
    localparam int OFF_POL   = 'h10;
    localparam int OFF_EDGE  = 'h14;
    localparam int OFF_MAP0  = 'h20;
    localparam int MAP_EN_BIT = 8;

    // encoding is {edge, polarity}
    typedef enum logic [1:0] {
        TRIG_LVL_LOW   = 2'b00,
        TRIG_LVL_HIGH  = 2'b01,
        TRIG_EDGE_FALL = 2'b10,
        TRIG_EDGE_RISE = 2'b11
    } trig_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] level_prev
);
    logic [W-1:0] meta_q, lvl_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign level      = lvl_q;
    assign level_prev = prev_q;
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
    import gpio_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] level,
    input  logic [NLINES-1:0] level_prev,
    input  logic [NLINES-1:0] pol,
    input  logic [NLINES-1:0] edg,
    input  logic [NLINES-1:0] mask,
    output logic [NLINES-1:0] cond
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        trig_kind_e kind;
        logic       hit;

        assign kind = trig_kind_e'({edg[i], pol[i]});

        always_comb begin
            unique case (kind)
                TRIG_LVL_LOW:   hit = ~level[i];
                TRIG_LVL_HIGH:  hit = level[i];
                TRIG_EDGE_FALL: hit = level_prev[i] & ~level[i];
                TRIG_EDGE_RISE: hit = level[i] & ~level_prev[i];
            endcase
        end

        assign cond[i] = hit & mask[i];

        AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            (cond[i] && edg[i]) ##1 (edg[i] && (pol[i] == $past(pol[i]))) |-> !cond[i]); // R6 R7
    end
endmodule

// File: rtl/gpio_router.sv
module gpio_router #(
    parameter int NLINES = 32,
    parameter int NIRQ   = 4,
    parameter int IDXW   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NLINES-1:0]          cond,
    input  logic [NLINES-1:0]          map_en,
    input  logic [NLINES-1:0][IDXW-1:0] map_idx,
    output logic [NIRQ-1:0]            irq_out
);
    for (genvar k = 0; k < NIRQ; k++) begin : g_out
        always_comb begin
            irq_out[k] = 1'b0;
            for (int j = 0; j < NLINES; j++) begin
                if (map_en[j] && (map_idx[j] == IDXW'(k)))
                    irq_out[k] = irq_out[k] | cond[j];
            end
        end
    end

    AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (map_en == '0) |-> (irq_out == '0)); // R9
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int NIRQ   = 4,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic [NIRQ-1:0]   irq_out
);
    localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [NLINES-1:0]           out_q, dir_q, mask_q, pol_q, edge_q;
    logic [NLINES-1:0]           map_en_q;
    logic [NLINES-1:0][IDXW-1:0] map_idx_q;
    logic [NLINES-1:0]           lvl, lvl_prev, cond;
    logic [31:0]                 rdata_c;

    function automatic logic [AW-1:0] map_addr(input int j);
        return AW'(OFF_MAP0 + 4 * j);
    endfunction

    gpio_sync #(.W(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in),
        .level(lvl), .level_prev(lvl_prev)
    );

    gpio_trigger #(.NLINES(NLINES)) u_trig (
        .clk(clk), .rst_n(rst_n), .level(lvl), .level_prev(lvl_prev),
        .pol(pol_q), .edg(edge_q), .mask(mask_q), .cond(cond)
    );

    gpio_router #(.NLINES(NLINES), .NIRQ(NIRQ), .IDXW(IDXW)) u_route (
        .clk(clk), .rst_n(rst_n), .cond(cond),
        .map_en(map_en_q), .map_idx(map_idx_q), .irq_out(irq_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= '0;
            dir_q     <= '0;
            mask_q    <= '0;
            pol_q     <= '0;
            edge_q    <= '0;
            map_en_q  <= '0;
            map_idx_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                AW'(OFF_OUT):  out_q  <= bus_wdata[NLINES-1:0];
                AW'(OFF_DIR):  dir_q  <= bus_wdata[NLINES-1:0];
                AW'(OFF_MASK): mask_q <= bus_wdata[NLINES-1:0];
                AW'(OFF_POL):  pol_q  <= bus_wdata[NLINES-1:0];
                AW'(OFF_EDGE): edge_q <= bus_wdata[NLINES-1:0];
                default: ;
            endcase
            for (int j = 0; j < NLINES; j++) begin
                if (bus_addr == map_addr(j)) begin
                    map_en_q[j]  <= bus_wdata[MAP_EN_BIT];
                    map_idx_q[j] <= bus_wdata[IDXW-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata_c = '0;
        case (bus_addr)
            AW'(OFF_DATA): rdata_c = 32'(lvl);
            AW'(OFF_OUT):  rdata_c = 32'(out_q);
            AW'(OFF_DIR):  rdata_c = 32'(dir_q);
            AW'(OFF_MASK): rdata_c = 32'(mask_q);
            AW'(OFF_POL):  rdata_c = 32'(pol_q);
            AW'(OFF_EDGE): rdata_c = 32'(edge_q);
            default: ;
        endcase
        for (int j = 0; j < NLINES; j++) begin
            if (bus_addr == map_addr(j)) begin
                rdata_c             = 32'(map_idx_q[j]);
                rdata_c[MAP_EN_BIT] = map_en_q[j];
            end
        end
    end

    assign bus_rdata = rdata_c;
    assign pin_out   = out_q;
    assign pin_oe    = dir_q;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0) && (pin_out == '0) && (irq_out == '0)); // R1
    AST_OE_AFTER_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFF_DIR)) |=> (pin_oe == $past(bus_wdata[NLINES-1:0]))); // R2
    AST_DATA_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFF_DATA)) |=> ($stable(pin_oe) && $stable(pin_out))); // R3
    AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (irq_out == '0)); // R8
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    localparam int NL = 24;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    addr;
    logic          we;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [NL-1:0] pin_in, pin_out, pin_oe;
    logic [NI-1:0] irq;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_irq_port #(.NLINES(NL), .NIRQ(NI), .AW(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq)
    );

    typedef struct packed {
        logic pol;
        logic msk;
        logic pin;
        logic exp;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pin_in = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(8'h04, v); check("R1 out reg", v, 0);
        rd(8'h08, v); check("R1 dir reg", v, 0);
        rd(8'h0C, v); check("R1 mask reg", v, 0);
        rd(8'h10, v); check("R1 pol reg", v, 0);
        rd(8'h14, v); check("R1 edge reg", v, 0);
        rd(8'h20, v); check("R1 map0 reg", v, 0);
        check("R1 pins", {pin_oe, pin_out}, 0);
        check("R1 irq", 32'(irq), 0);

        // R2 output and direction
        wr(8'h04, 32'h00A5A5A5);
        wr(8'h08, 32'h000F0F0F);
        rd(8'h04, v); check("R2 out readback", v, 32'h00A5A5A5);
        rd(8'h08, v); check("R2 dir readback", v, 32'h000F0F0F);
        check("R2 pin_out", 32'(pin_out), 32'h00A5A5A5);
        check("R2 pin_oe", 32'(pin_oe), 32'h000F0F0F);

        // R3 synchroniser latency and read-only input register
        pin_in = 24'h123456;
        cyc(1);
        rd(8'h00, v); check("R3 one edge", v, 0);
        cyc(1);
        rd(8'h00, v); check("R3 two edges", v, 32'h00123456);
        wr(8'h00, 32'hFFFFFFFF);
        rd(8'h00, v); check("R3 write ignored", v, 32'h00123456);
        check("R3 pins unchanged", 32'(pin_out), 32'h00A5A5A5);
        pin_in = '0;
        cyc(3);

        // R4 R5 R8 level table, line 5 routed to output 2
        wr(8'h34, 32'h00000102);
        for (int i = 0; i < 6; i++) begin
            wr(8'h10, 32'(VECS[i].pol) << 5);
            wr(8'h0C, 32'(VECS[i].msk) << 5);
            pin_in[5] = VECS[i].pin;
            cyc(3);
            check(!VECS[i].msk ? "R8 masked level" : (VECS[i].pol ? "R5 level high" : "R4 level low"),
                  32'(irq), VECS[i].exp ? 32'h4 : 32'h0);
        end
        wr(8'h0C, 0); wr(8'h10, 0); pin_in = '0;

        // R6 falling edge, line 3 routed to output 1
        wr(8'h2C, 32'h00000101);
        pin_in[3] = 1'b1;
        cyc(3);
        wr(8'h14, 32'h8);
        wr(8'h0C, 32'h8);
        check("R6 steady high no event", 32'(irq), 0);
        pin_in[3] = 1'b0;
        cyc(1); check("R6 after one edge", 32'(irq), 0);
        cyc(1); check("R6 pulse", 32'(irq), 32'h2);
        cyc(1); check("R6 pulse ends", 32'(irq), 0);

        // R7 rising edge
        wr(8'h10, 32'h8);
        pin_in[3] = 1'b1;
        cyc(1); check("R7 after one edge", 32'(irq), 0);
        cyc(1); check("R7 pulse", 32'(irq), 32'h2);
        cyc(1); check("R7 pulse ends", 32'(irq), 0);

        // R8 masked edge
        wr(8'h0C, 0);
        pin_in[3] = 1'b0;
        cyc(3);
        pin_in[3] = 1'b1;
        cyc(2); check("R8 masked edge", 32'(irq), 0);
        wr(8'h14, 0); wr(8'h10, 0); pin_in = '0;

        // R9 map enable and index
        wr(8'h10, 32'h20); wr(8'h0C, 32'h20);
        pin_in[5] = 1'b1;
        wr(8'h34, 32'h00000002);
        cyc(3); check("R9 enable clear", 32'(irq), 0);
        wr(8'h34, 32'h00000103);
        check("R9 index 3", 32'(irq), 32'h8);
        rd(8'h34, v); check("R9 map readback", v, 32'h103);
        wr(8'h34, 32'hFFFFFFFF);
        rd(8'h34, v); check("R9 map unstored bits", v, 32'h103);

        // R10 sharing
        wr(8'h34, 32'h100); wr(8'h38, 32'h100);
        wr(8'h10, 32'h60); wr(8'h0C, 32'h60);
        pin_in[6:5] = 2'b01; cyc(3); check("R10 first only", 32'(irq), 32'h1);
        pin_in[6:5] = 2'b11; cyc(3); check("R10 both", 32'(irq), 32'h1);
        pin_in[6:5] = 2'b10; cyc(3); check("R10 second only", 32'(irq), 32'h1);
        pin_in[6:5] = 2'b00; cyc(3); check("R10 none", 32'(irq), 32'h0);
        wr(8'h38, 32'h103);
        pin_in[6:5] = 2'b11; cyc(3); check("R10 split outputs", 32'(irq), 32'h9);
        wr(8'h0C, 0); pin_in = '0;

        // R11 unimplemented bits and offsets
        wr(8'h08, 32'hFFFFFFFF);
        rd(8'h08, v); check("R11 dir upper bits", v, 32'h00FFFFFF);
        check("R11 pin_oe", 32'(pin_oe), 32'h00FFFFFF);
        wr(8'h98, 32'hFFFFFFFF);
        rd(8'h98, v); check("R11 map of absent line", v, 0);
        wr(8'h18, 32'hFFFFFFFF);
        rd(8'h18, v); check("R11 unassigned offset", v, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule